// File: doc/BRIEF.md
# SPI-Mode Card Read Start-Token Waiter

This block waits for a memory card in SPI mode to begin a data block. Once started, it asks a byte-exchange SPI port for one byte at a time and always sends the all-ones dummy value. It checks each byte that comes back. The search ends in one of three ways:

- the card returns the read start token, which is a success;
- the card returns a data error token, which is reported with an error class;
- a set number of byte reads completes without either token, which is reported as a timeout.

The result is a one-cycle completion pulse, a success flag and a two-bit error code. Receiving the payload and checking its CRC happen elsewhere.

The bound on the number of reads is a parameter. Its default is 500000 reads. At a 25 MHz serial clock, 100 ms of access time is 312500 byte times, so the default is above that. A simulation can set the bound to a small value.

Top module: `sdspi_tok_wait`

## Requirements
- R1: A start request is accepted only when the block is idle and the block-boundary input is high. A start request while that input is low issues no byte request and produces no completion pulse.
- R2: Each poll is a one-cycle byte request with the transmit byte equal to 0xFF. No further request is issued until the acknowledge for the previous one has returned.
- R3: The returned byte 0xFE ends the search with a completion pulse, success flag 1 and error code 0.
- R4: A data error token is a byte whose upper nibble is 0 and whose lower nibble is non-zero. If any of its bits 2:0 is set, the search ends with success 0 and error code 2 (CRC class).
- R5: A data error token with only bit 3 set ends the search with success 0 and error code 3 (out of range).
- R6: Any other returned byte, including 0x00 and 0xFF, does not end the search. The next poll is issued.
- R7: After POLL_LIMIT reads without a terminating byte, no further request is issued. The search ends with success 0 and error code 1 (timeout).
- R8: The completion pulse lasts one cycle. The success flag and the error code hold their values until the next start request is accepted, which clears both.
- R9: After reset there is no byte request and no completion pulse, and the success flag and error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin searching for the start token |
| blk_aligned_i | input | 1 | High when the transfer position is on a block boundary |
| byte_req_o | output | 1 | One-cycle request to exchange one byte |
| byte_tx_o | output | 8 | Byte to transmit (always 0xFF) |
| byte_ack_i | input | 1 | Exchange complete; byte_rx_i is valid |
| byte_rx_i | input | 8 | Byte received from the card |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Start token found |
| err_o | output | 2 | 0 none, 1 timeout, 2 CRC class, 3 out of range |

## Verification
The hardest outcome to reach is the timeout, because the card would have to stay silent for the full read budget. The bench sets POLL_LIMIT to 5 and makes a modelled responder repeat a non-terminating byte, so the bound is reached in a few cycles.

Every one of the 256 byte values is returned as the reply, and the bench computes the expected class from the byte itself. Runs with non-terminating filler bytes placed ahead of the start token land exactly on, and one past, the last allowed read.

// File: rtl/sdspi_tok_pkg.sv
package sdspi_tok_pkg;

    localparam logic [7:0] TOK_START  = 8'hFE;
    localparam logic [7:0] TX_DUMMY   = 8'hFF;
    localparam logic [3:0] CRC_CLASS  = 4'b0111;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_CRC     = 2'd2,
        ERR_RANGE   = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        state_e st;
        logic   done;
        logic   ok;
        err_e   err;
    } ctl_t;

endpackage

// File: rtl/sdspi_tok_classify.sv
module sdspi_tok_classify
    import sdspi_tok_pkg::*;
(
    input  logic [7:0] rx_i,
    output logic       is_start_o,
    output logic       is_err_o,
    output err_e       err_cls_o
);
    always_comb begin
        is_start_o = (rx_i == TOK_START);
        // error token: zero upper nibble, some lower flag set
        is_err_o   = (rx_i[7:4] == 4'h0) && (rx_i[3:0] != 4'h0);
        err_cls_o  = ((rx_i[3:0] & CRC_CLASS) != 4'h0) ? ERR_CRC : ERR_RANGE;
    end
endmodule

// File: rtl/sdspi_tok_pollcnt.sv
module sdspi_tok_pollcnt #(
    parameter int unsigned POLL_LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_o = (cnt_q == CW'(POLL_LIMIT));
endmodule

// File: rtl/sdspi_tok_wait.sv
module sdspi_tok_wait
    import sdspi_tok_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       blk_aligned_i,
    output logic       byte_req_o,
    output logic [7:0] byte_tx_o,
    input  logic       byte_ack_i,
    input  logic [7:0] byte_rx_i,
    output logic       done_o,
    output logic       ok_o,
    output logic [1:0] err_o
);
    ctl_t ctl_d, ctl_q;
    logic cnt_clr, cnt_inc, cnt_hit;
    logic is_start, is_err;
    err_e err_cls;

    sdspi_tok_classify u_cls (
        .rx_i       (byte_rx_i),
        .is_start_o (is_start),
        .is_err_o   (is_err),
        .err_cls_o  (err_cls)
    );

    sdspi_tok_pollcnt #(.POLL_LIMIT(POLL_LIMIT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .hit_o (cnt_hit)
    );

    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i && blk_aligned_i) begin
                    ctl_d.st  = ST_ISSUE;
                    ctl_d.ok  = 1'b0;
                    ctl_d.err = ERR_NONE;
                    cnt_clr   = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (cnt_hit) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.err  = ERR_TIMEOUT;
                end else begin
                    cnt_inc  = 1'b1;
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (byte_ack_i) begin
                    if (is_start) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.ok   = 1'b1;
                    end else if (is_err) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.err  = err_cls;
                    end else begin
                        ctl_d.st = ST_ISSUE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, done: 1'b0, ok: 1'b0, err: ERR_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign byte_req_o = (ctl_q.st == ST_ISSUE) && !cnt_hit;
    assign byte_tx_o  = TX_DUMMY;
    assign done_o     = ctl_q.done;
    assign ok_o       = ctl_q.ok;
    assign err_o      = ctl_q.err;
endmodule

// File: rtl/sdspi_tok_wait_chk.sv
module sdspi_tok_wait_chk #(
    parameter int unsigned POLL_LIMIT = 500000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_req_o,
    input logic       byte_ack_i,
    input logic       done_o,
    input logic       ok_o,
    input logic [1:0] err_o
);
    localparam int unsigned CW = $clog2(POLL_LIMIT + 2);

    logic          pend_q;
    logic [CW-1:0] reqs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            reqs_q <= '0;
        end else begin
            if (byte_req_o)      pend_q <= 1'b1;
            else if (byte_ack_i) pend_q <= 1'b0;
            if (done_o)          reqs_q <= '0;
            else if (byte_req_o) reqs_q <= reqs_q + 1'b1;
        end
    end

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req_o |=> !byte_req_o);

    assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req_o |-> !pend_q);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ok_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (err_o == 2'd0));

    assert_fail_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> (err_o != 2'd0));

    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req_o |-> (reqs_q < CW'(POLL_LIMIT)));
endmodule

bind sdspi_tok_wait sdspi_tok_wait_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_req_o (byte_req_o),
    .byte_ack_i (byte_ack_i),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .err_o      (err_o)
);

// File: tb/sdspi_tok_wait_bench.sv
`timescale 1ns/1ps
module sdspi_tok_wait_bench;
    localparam int LIMIT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       blk_aligned_i = 1'b0;
    logic       byte_req_o;
    logic [7:0] byte_tx_o;
    logic       byte_ack_i = 1'b0;
    logic [7:0] byte_rx_i = 8'h00;
    logic       done_o;
    logic       ok_o;
    logic [1:0] err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdspi_tok_wait #(.POLL_LIMIT(LIMIT)) u_sdspi_tok_wait (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_aligned_i(blk_aligned_i),
        .byte_req_o(byte_req_o), .byte_tx_o(byte_tx_o), .byte_ack_i(byte_ack_i),
        .byte_rx_i(byte_rx_i), .done_o(done_o), .ok_o(ok_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one search: nfill filler bytes, then 'last' repeated
    task automatic session(input logic [7:0] last, input logic [7:0] fill, input int nfill,
                           input int dly, output int reqs, output logic fin,
                           output logic okv, output logic [1:0] ev);
        int cyc;
        reqs = 0; fin = 1'b0; okv = 1'b0; ev = 2'd0; cyc = 0;
        start_i = 1'b1; blk_aligned_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 cleared on start", {31'd0, ok_o} + {30'd0, err_o}, 0);
        while (!fin && cyc < 400) begin
            if (done_o) begin
                fin = 1'b1; okv = ok_o; ev = err_o;
            end else if (byte_req_o) begin
                reqs++;
                if (byte_tx_o != 8'hFF) chk("R2 tx dummy", byte_tx_o, 8'hFF);
                repeat (dly) @(negedge clk);
                if (byte_req_o) chk("R2 single-cycle request", 1, 0);
                byte_ack_i = 1'b1;
                byte_rx_i  = (reqs <= nfill) ? fill : last;
                @(negedge clk);
                byte_ack_i = 1'b0;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int reqs;
        logic fin, okv;
        logic [1:0] ev;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 req after reset", byte_req_o, 0);
        chk("R9 done after reset", done_o, 0);
        chk("R9 ok after reset", ok_o, 0);
        chk("R9 err after reset", err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: unaligned start ignored
        start_i = 1'b1; blk_aligned_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (byte_req_o || done_o) begin
                chk("R1 unaligned start ignored", 1, 0);
                break;
            end
            @(negedge clk);
        end
        chk("R1 no activity after unaligned start", {31'd0, byte_req_o | done_o}, 0);

        // sweep every reply value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            int eok, eerr, ereq;
            b = 8'(v);
            if (b == 8'hFE) begin
                eok = 1; eerr = 0; ereq = 1;
            end else if (b[7:4] == 4'h0 && b[3:0] != 4'h0) begin
                eok = 0; eerr = (b[2:0] != 3'b0) ? 2 : 3; ereq = 1;
            end else begin
                eok = 0; eerr = 1; ereq = LIMIT;
            end
            session(b, 8'hFF, 0, 1 + (v % 3), reqs, fin, okv, ev);
            chk("R3 R4 R5 R6 R7 finished", fin, 1);
            chk("R3 R4 R5 ok flag", okv, eok);
            chk("R3 R4 R5 R7 error code", ev, eerr);
            chk("R6 R7 request count", reqs, ereq);
            @(negedge clk);
            chk("R8 done one cycle", done_o, 0);
            chk("R8 ok held", ok_o, eok);
            chk("R8 err held", err_o, eerr);
        end

        // filler then start token: boundary on the last allowed read
        for (int n = 0; n <= LIMIT; n++) begin
            logic [7:0] f;
            f = (n % 3 == 0) ? 8'h00 : ((n % 3 == 1) ? 8'h10 : 8'hFF);
            session(8'hFE, f, n, 2, reqs, fin, okv, ev);
            chk("R6 R7 finished after filler", fin, 1);
            chk("R6 R7 ok after filler", okv, (n < LIMIT) ? 1 : 0);
            chk("R6 R7 err after filler", ev, (n < LIMIT) ? 0 : 1);
            chk("R7 requests after filler", reqs, (n < LIMIT) ? n + 1 : LIMIT);
            repeat (2) @(negedge clk);
        end

        // R1: start ignored while a search runs
        session(8'h20, 8'hFF, 0, 1, reqs, fin, okv, ev);
        chk("R7 timeout before restart", ev, 1);
        start_i = 1'b1; blk_aligned_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 R2 request after accepted start", byte_req_o, 1);
        start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        byte_ack_i = 1'b1; byte_rx_i = 8'h08;
        @(negedge clk);
        byte_ack_i = 1'b0;
        chk("R5 range after ignored start", {31'd0, done_o}, 1);
        chk("R5 range code", err_o, 3);
        @(negedge clk);
        chk("R1 no restart from start during search", byte_req_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule